// File: doc/BRIEF.md
# Mapper Register Slave with Four-Phase Handshake

This block holds the processor-visible registers of a two-sided payload mapper: an insert side and an extract side. Each side has a control enable, a status view, a two-bit interrupt status register with its enable mask, and a two-bit overhead field. The extract side also has a high and a low FIFO fill mark. A processor reaches them over an 8-bit bus with a 4-bit address, separate write and read data, a select, and a read/write line.

The select may come from another clock domain. It passes through a two-flop synchronizer, and each access is carried out exactly once, on the synchronized rising edge of select. The acknowledge then stays high until select is removed, which gives a four-phase handshake. While select is low, the read data and the acknowledge are held at zero, so several slaves can be merged with a plain OR. Event inputs from the mapper datapath set sticky interrupt bits. A read of an interrupt status register clears it. The interrupt request is high while any enabled bit is pending.

Top module: `mapreg_slave`

## Requirements
- R1: Read/write registers return the value last written, with unused bits read as 0. Address 0x0 holds the insert enable in bit 0. Address 0x5 holds the extract enable in bit 0. Address 0x4 holds the insert overhead in bits 1:0. Address 0xA holds the high mark in bits 4:0 and address 0xB the low mark in bits 4:0.
- R2: Read-only locations ignore writes. Address 0x1 returns the insert status input in bits 1:0. Address 0x6 returns the extract status input in bits 1:0. Address 0x9 returns the extract overhead input in bits 1:0. Addresses 0xC to 0xF return 0.
- R3: After select rises, the acknowledge goes high within 4 clock cycles. It stays high for as long as select stays high.
- R4: While select is low, the acknowledge and the read data are both 0.
- R5: An access is carried out only once per select assertion. An interrupt event that arrives after the clearing read, while select is still held high, remains pending.
- R6: An event input sets its interrupt bit, and the bit stays set until it is cleared. Bit 1 is FIFO corrupt and bit 0 is pattern corrupt. The insert side is at 0x2 and the extract side at 0x7.
- R7: A read of 0x2 or 0x7 returns the pending bits and clears them. Writes to 0x2 or 0x7 have no effect.
- R8: An event that arrives in the same cycle as the clearing read sets its bit again.
- R9: The interrupt enable registers at 0x3 (insert) and 0x8 (extract) are read/write in bits 1:0, with the same bit positions as the status bits. The interrupt request is high exactly when some pending bit has its enable set.
- R10: After reset, every register and every control output is 0, and the interrupt request is low.
- R11: The control outputs always show the current contents of the enable, insert overhead and mark registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Bus select; may be asynchronous |
| rd_i | input | 1 | 1 = read access, 0 = write access |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data; 0 while not selected |
| ack_o | output | 1 | Acknowledge; 0 while not selected |
| ins_status_i | input | 2 | Insert side status view |
| ext_status_i | input | 2 | Extract side status view |
| ext_oh_i | input | 2 | Overhead bits received on the extract side |
| ins_evt_i | input | 2 | Insert events: bit 1 FIFO corrupt, bit 0 pattern corrupt |
| ext_evt_i | input | 2 | Extract events: bit 1 FIFO corrupt, bit 0 pattern corrupt |
| ins_en_o | output | 1 | Insert side enable |
| ext_en_o | output | 1 | Extract side enable |
| ins_oh_o | output | 2 | Overhead bits to insert |
| hi_mark_o | output | 5 | FIFO high fill mark |
| lo_mark_o | output | 5 | FIFO low fill mark |
| irq_o | output | 1 | Interrupt request |

## Verification
Suppose the synchronizer or edge detector went wrong, for example by firing twice or never. The acknowledge would then never come, or a held select would clear an interrupt bit a second time. Either fault shows at the ports within a few cycles of select rising. A wrong decode or a lost write shows on the next read of that address, or at once on the control outputs. A stuck, lost or wrongly cleared interrupt bit shows on irq_o in the cycle after the event or the clearing read, provided its enable is set. It also shows in the value of the next status read.

// File: rtl/mapreg_pkg.sv
package mapreg_pkg;
  localparam int DW  = 8;
  localparam int AW  = 4;
  localparam int IW  = 2;
  localparam int OHW = 2;
  localparam int MKW = 5;
  localparam int STW = 2;

  typedef enum logic [AW-1:0] {
    A_INS_CTRL = 4'h0,
    A_INS_STAT = 4'h1,
    A_INS_ISR  = 4'h2,
    A_INS_IE   = 4'h3,
    A_INS_OH   = 4'h4,
    A_EXT_CTRL = 4'h5,
    A_EXT_STAT = 4'h6,
    A_EXT_ISR  = 4'h7,
    A_EXT_IE   = 4'h8,
    A_EXT_OH   = 4'h9,
    A_HI_MARK  = 4'hA,
    A_LO_MARK  = 4'hB
  } reg_addr_e;

  // per-side offsets from the side base (insert base 0, extract base 5)
  localparam int SIDE_STRIDE = 5;
  localparam int OFS_ISR     = 2;
  localparam int OFS_IE      = 3;

  // zero-extend a narrow field onto the data bus
  function automatic logic [DW-1:0] widen(input logic [DW-1:0] v, input int unsigned w);
    logic [DW-1:0] mask;
    mask = (DW'(1) << w) - DW'(1);
    return v & mask;
  endfunction

  function automatic logic pending(input logic [IW-1:0] isr, input logic [IW-1:0] ie);
    return |(isr & ie);
  endfunction
endpackage

// File: rtl/mapreg_sync.sv
module mapreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  output logic sel_sync_o,
  output logic strobe_o,
  output logic ack_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES:0] sq;
  logic            ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq <= '0;
    else        sq <= {sq[STAGES-1:0], sel_i};
  end

  assign sel_sync_o = sq[LAST];
  assign strobe_o   = sq[LAST] & ~sq[STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ack_q <= 1'b0;
    else if (strobe_o)   ack_q <= 1'b1;
    else if (!sq[LAST])  ack_q <= 1'b0;
  end

  // gate with raw select so the merged bus sees zero the moment select drops
  assign ack_o = ack_q & sel_i;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o); // R5
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && sq[LAST]) |=> ack_q); // R3
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sq[LAST] && !strobe_o) |=> !ack_q); // R4
endmodule

// File: rtl/mapreg_isr.sv
module mapreg_isr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  input  logic         ie_we_i,
  input  logic [W-1:0] ie_wdata_i,
  output logic [W-1:0] isr_o,
  output logic [W-1:0] ie_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_o <= '0;
      ie_o  <= '0;
    end else begin
      isr_o <= clr_i ? evt_i : (isr_o | evt_i);
      if (ie_we_i) ie_o <= ie_wdata_i;
    end
  end

  AST_ISR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((isr_o & $past(isr_o)) == $past(isr_o))); // R6
  AST_ISR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i == '0) |=> (isr_o == '0)); // R7
  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((isr_o & $past(evt_i)) == $past(evt_i))); // R8
endmodule

// File: rtl/mapreg_slave.sv
module mapreg_slave
  import mapreg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel_i,
  input  logic           rd_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic           ack_o,
  input  logic [STW-1:0] ins_status_i,
  input  logic [STW-1:0] ext_status_i,
  input  logic [OHW-1:0] ext_oh_i,
  input  logic [IW-1:0]  ins_evt_i,
  input  logic [IW-1:0]  ext_evt_i,
  output logic           ins_en_o,
  output logic           ext_en_o,
  output logic [OHW-1:0] ins_oh_o,
  output logic [MKW-1:0] hi_mark_o,
  output logic [MKW-1:0] lo_mark_o,
  output logic           irq_o
);
  localparam int NSIDE = 2;

  logic sel_sync, strobe, wr_stb, rd_stb;

  mapreg_sync #(.STAGES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel_i),
    .sel_sync_o(sel_sync),
    .strobe_o  (strobe),
    .ack_o     (ack_o)
  );

  assign wr_stb = strobe & ~rd_i;
  assign rd_stb = strobe &  rd_i;

  // interrupt status / enable per side
  logic [NSIDE-1:0][IW-1:0] side_evt, side_isr, side_ie;
  logic [NSIDE-1:0]         side_clr, side_iewe, side_pend;

  assign side_evt = {ext_evt_i, ins_evt_i};

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam logic [AW-1:0] ISR_A = AW'(s * SIDE_STRIDE + OFS_ISR);
    localparam logic [AW-1:0] IE_A  = AW'(s * SIDE_STRIDE + OFS_IE);
    assign side_clr[s]  = rd_stb & (addr_i == ISR_A);
    assign side_iewe[s] = wr_stb & (addr_i == IE_A);
    mapreg_isr #(.W(IW)) u_isr (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (side_evt[s]),
      .clr_i     (side_clr[s]),
      .ie_we_i   (side_iewe[s]),
      .ie_wdata_i(wdata_i[IW-1:0]),
      .isr_o     (side_isr[s]),
      .ie_o      (side_ie[s])
    );
    assign side_pend[s] = pending(side_isr[s], side_ie[s]);
  end

  assign irq_o = |side_pend;

  // plain read/write registers
  logic           ins_en_q, ext_en_q;
  logic [OHW-1:0] ins_oh_q;
  logic [MKW-1:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_en_q <= 1'b0;
      ext_en_q <= 1'b0;
      ins_oh_q <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else if (wr_stb) begin
      case (addr_i)
        A_INS_CTRL: ins_en_q <= wdata_i[0];
        A_EXT_CTRL: ext_en_q <= wdata_i[0];
        A_INS_OH:   ins_oh_q <= wdata_i[OHW-1:0];
        A_HI_MARK:  hi_q     <= wdata_i[MKW-1:0];
        A_LO_MARK:  lo_q     <= wdata_i[MKW-1:0];
        default: ;
      endcase
    end
  end

  assign ins_en_o  = ins_en_q;
  assign ext_en_o  = ext_en_q;
  assign ins_oh_o  = ins_oh_q;
  assign hi_mark_o = hi_q;
  assign lo_mark_o = lo_q;

  // read multiplexer, captured on the access strobe
  logic [DW-1:0] rd_mux, rdata_q;

  always_comb begin
    case (addr_i)
      A_INS_CTRL: rd_mux = widen(DW'(ins_en_q), 1);
      A_INS_STAT: rd_mux = widen(DW'(ins_status_i), STW);
      A_INS_ISR:  rd_mux = widen(DW'(side_isr[0]), IW);
      A_INS_IE:   rd_mux = widen(DW'(side_ie[0]), IW);
      A_INS_OH:   rd_mux = widen(DW'(ins_oh_q), OHW);
      A_EXT_CTRL: rd_mux = widen(DW'(ext_en_q), 1);
      A_EXT_STAT: rd_mux = widen(DW'(ext_status_i), STW);
      A_EXT_ISR:  rd_mux = widen(DW'(side_isr[1]), IW);
      A_EXT_IE:   rd_mux = widen(DW'(side_ie[1]), IW);
      A_EXT_OH:   rd_mux = widen(DW'(ext_oh_i), OHW);
      A_HI_MARK:  rd_mux = widen(DW'(hi_q), MKW);
      A_LO_MARK:  rd_mux = widen(DW'(lo_q), MKW);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_stb) rdata_q <= rd_mux;
    else if (wr_stb) rdata_q <= '0;
  end

  assign rdata_o = ack_o ? rdata_q : '0;

  AST_HI_MARK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr_i == A_HI_MARK) |=> (hi_mark_o == $past(wdata_i[MKW-1:0]))); // R1
  AST_RO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb) |=> $stable(ins_oh_o) && $stable(hi_mark_o) && $stable(lo_mark_o)); // R11
endmodule

// File: tb/mapreg_slave_bench.sv
`timescale 1ns/1ps
module mapreg_slave_bench;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic       sel = 0, rd = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       ack;
  logic [1:0] ins_st = 0, ext_st = 0, ext_oh = 0, ins_ev = 0, ext_ev = 0;
  logic       ins_en, ext_en, irq;
  logic [1:0] ins_oh;
  logic [4:0] hi, lo;

  mapreg_slave u_mapreg_slave (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack),
    .ins_status_i(ins_st), .ext_status_i(ext_st), .ext_oh_i(ext_oh),
    .ins_evt_i(ins_ev), .ext_evt_i(ext_ev),
    .ins_en_o(ins_en), .ext_en_o(ext_en), .ins_oh_o(ins_oh),
    .hi_mark_o(hi), .lo_mark_o(lo), .irq_o(irq));

  int checks = 0, fails = 0;
  int cyc = 0;

  // bench model
  logic       m_ins_en, m_ext_en;
  logic [1:0] m_ins_oh, m_ins_isr, m_ext_isr, m_ins_ie, m_ext_ie;
  logic [4:0] m_hi, m_lo;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [3:0] a);
    case (a)
      4'h0: return {7'd0, m_ins_en};
      4'h1: return {6'd0, ins_st};
      4'h2: return {6'd0, m_ins_isr};
      4'h3: return {6'd0, m_ins_ie};
      4'h4: return {6'd0, m_ins_oh};
      4'h5: return {7'd0, m_ext_en};
      4'h6: return {6'd0, ext_st};
      4'h7: return {6'd0, m_ext_isr};
      4'h8: return {6'd0, m_ext_ie};
      4'h9: return {6'd0, ext_oh};
      4'hA: return {3'd0, m_hi};
      4'hB: return {3'd0, m_lo};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic model_irq();
    return |(m_ins_isr & m_ins_ie) | |(m_ext_isr & m_ext_ie);
  endfunction

  task automatic model_write(input logic [3:0] a, input logic [7:0] d);
    case (a)
      4'h0: m_ins_en = d[0];
      4'h3: m_ins_ie = d[1:0];
      4'h4: m_ins_oh = d[1:0];
      4'h5: m_ext_en = d[0];
      4'h8: m_ext_ie = d[1:0];
      4'hA: m_hi = d[4:0];
      4'hB: m_lo = d[4:0];
      default: ;
    endcase
  endtask

  task automatic check_outputs(input string tag);
    chk({tag, " R11 ins_en"}, ins_en, m_ins_en);
    chk({tag, " R11 ext_en"}, ext_en, m_ext_en);
    chk({tag, " R11 ins_oh"}, ins_oh, m_ins_oh);
    chk({tag, " R11 hi"}, hi, m_hi);
    chk({tag, " R11 lo"}, lo, m_lo);
    chk({tag, " R9 irq"}, irq, model_irq());
  endtask

  // one bus access; sel driven at negedge, ack expected within 4 cycles
  task automatic access(input logic r, input logic [3:0] a, input logic [7:0] d,
                        output logic [7:0] q);
    int n;
    @(negedge clk);
    rd = r; addr = a; wdata = d; sel = 1;
    n = 0;
    while (!ack && n < 10) begin @(negedge clk); n++; end
    chk("R3 ack arrives", (n <= 4), 1);
    q = rdata;
    repeat (2) @(negedge clk);
    chk("R3 ack held", ack, 1);
    chk("R5 read data held", rdata, q);
    sel = 0;
    #0.5;
    chk("R4 ack idle", ack, 0);
    chk("R4 rdata idle", rdata, 0);
    repeat (4) @(negedge clk);
    chk("R4 ack stays idle", ack, 0);
  endtask

  task automatic do_read(input logic [3:0] a, input string req);
    logic [7:0] q, e;
    e = model_read(a);
    access(1, a, 8'h00, q);
    chk(req, q, e);
    if (a == 4'h2) m_ins_isr = 2'b00;
    if (a == 4'h7) m_ext_isr = 2'b00;
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] q;
    access(0, a, d, q);
    model_write(a, d);
  endtask

  task automatic pulse_evt(input logic [1:0] iv, input logic [1:0] ev);
    @(negedge clk);
    ins_ev = iv; ext_ev = ev;
    @(negedge clk);
    ins_ev = 0; ext_ev = 0;
    m_ins_isr |= iv; m_ext_isr |= ev;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    int seed;
    seed = 1234;
    void'($urandom(seed));
    m_ins_en = 0; m_ext_en = 0; m_ins_oh = 0; m_ins_isr = 0; m_ext_isr = 0;
    m_ins_ie = 0; m_ext_ie = 0; m_hi = 0; m_lo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    chk("R10 irq", irq, 0);
    chk("R10 ack", ack, 0);
    chk("R10 rdata", rdata, 0);
    for (int a = 0; a < 16; a++) do_read(4'(a), "R10 reset read");
    check_outputs("R10");

    // R1 read/write with unused bits dropped
    do_write(4'hA, 8'hFF); do_read(4'hA, "R1 hi mark");
    do_write(4'hB, 8'hB3); do_read(4'hB, "R1 lo mark");
    do_write(4'h4, 8'hFE); do_read(4'h4, "R1 ins oh");
    do_write(4'h0, 8'hF1); do_read(4'h0, "R1 ins ctrl");
    do_write(4'h5, 8'h03); do_read(4'h5, "R1 ext ctrl");
    check_outputs("R1");

    // R2 read-only and unused addresses
    ins_st = 2'b10; ext_st = 2'b01; ext_oh = 2'b11;
    do_write(4'h1, 8'hFF); do_write(4'h6, 8'hFF); do_write(4'h9, 8'h00);
    do_write(4'hC, 8'hFF); do_write(4'hF, 8'hFF);
    do_read(4'h1, "R2 ins stat"); do_read(4'h6, "R2 ext stat");
    do_read(4'h9, "R2 ext oh");   do_read(4'hC, "R2 unused C");
    do_read(4'hF, "R2 unused F");
    check_outputs("R2");

    // R6 / R9 events, enables, irq
    pulse_evt(2'b01, 2'b00);
    @(negedge clk); chk("R9 irq masked", irq, 0);
    do_write(4'h3, 8'hFD);
    @(negedge clk); chk("R9 irq enabled", irq, 1);
    do_read(4'h3, "R9 ins ie");
    pulse_evt(2'b00, 2'b10);
    do_write(4'h2, 8'h00);
    do_read(4'h7, "R6 ext fifo corrupt");
    do_read(4'h7, "R7 ext cleared");
    do_read(4'h2, "R7 ins read clear value");
    @(negedge clk); chk("R9 irq after clear", irq, 0);
    do_read(4'h2, "R7 ins cleared");

    // R8 event in the same cycle as the clearing read
    m_ext_ie = 2'b11;
    do_write(4'h8, 8'h03);
    pulse_evt(2'b00, 2'b01);
    @(negedge clk);
    rd = 1; addr = 4'h7; sel = 1;
    @(posedge clk); @(posedge clk);   // strobe now active
    @(negedge clk); ext_ev = 2'b10;   // coincides with the clearing edge
    @(negedge clk); ext_ev = 2'b00;
    chk("R8 read value", rdata, 8'h01);
    chk("R8 irq kept", irq, 1);
    // R5 event while select still held must not be cleared again
    @(negedge clk); ext_ev = 2'b01;
    @(negedge clk); ext_ev = 2'b00;
    repeat (3) @(negedge clk);
    sel = 0;
    repeat (4) @(negedge clk);
    m_ext_isr = 2'b11;
    do_read(4'h7, "R5 R8 pending after held read");
    check_outputs("R8");

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 15));
      ins_st = 2'($urandom); ext_st = 2'($urandom); ext_oh = 2'($urandom);
      if ($urandom_range(0, 3) == 0) pulse_evt(2'($urandom), 2'($urandom));
      if ($urandom_range(0, 1) == 0) do_read(a, "R1 R2 R7 random read");
      else do_write(a, 8'($urandom));
      @(negedge clk);
      check_outputs("random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule